// File: doc/BRIEF.md
# Sensorless Boost Inductor Current Estimator

This block produces a running estimate of the inductor current in a boost power-factor stage without measuring that current. On every system clock it adds the volt-seconds the inductor sees: the input voltage while the switch is driven on, and the input voltage minus the output voltage while it is off. The switch drive comes from the controller itself, so its state is exactly known. A signed trim word is added on every clock to soak up the combined effect of drive-edge delays and measurement offsets.

The two voltages come from slow converters whose samples arrive once every 2^FRAC_BITS system clocks. To cancel the delay that sampling and registering add, each voltage channel keeps the slope between its last two samples. Between strobes it advances the voltage by one slope fraction per clock, which is a straight-line extrapolation. The estimate is held in a wide accumulator with guard bits, floored at zero for discontinuous conduction, and scaled down by a fixed shift in place of the 1/L gain. The extrapolated voltages are also driven out for the control law that consumes them.

Top module: `boost_current_rebuilder`

## Requirements
- R1: A synchronous reset brings `i_est`, `vin_extrap` and `vo_extrap` to 0 on the next clock edge. It also clears the stored slopes and marks both channels as having no sample yet.
- R2: When a channel's valid strobe is high at a clock edge, that channel's extrapolated output equals the strobed sample after the edge.
- R3: The first strobe after reset sets the slope to zero, so the extrapolated output holds the sample until the next strobe.
- R4: Each later strobe stores the slope d = v[n] - v[n-1]. The internal voltage carries FRAC_BITS fraction bits and gains d fraction units per clock, so k clocks after the strobe the output is floor((v[n]*2^FRAC_BITS + k*d) / 2^FRAC_BITS).
- R5: The internal extrapolated voltage saturates at 0 and at 2^(VW+FRAC_BITS)-1. The output therefore stays within 0 to 2^VW-1.
- R6: With `sw_on` high, the accumulator gains the registered `vin_extrap` plus the signed `comp_trim` on each clock.
- R7: With `sw_on` low, the accumulator gains `vin_extrap` minus `vo_extrap` plus `comp_trim` on each clock. It falls when the output voltage exceeds the input voltage.
- R8: A clock whose sum would be negative leaves the accumulator at exactly 0.
- R9: A clock whose sum would exceed 2^(IW+GAIN_SHIFT)-1 leaves the accumulator at that maximum.
- R10: `i_est` equals the accumulator shifted right by GAIN_SHIFT bits. The voltage terms used on a clock are the extrapolated outputs registered at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the PWM time step |
| rst | input | 1 | Synchronous reset, active high |
| vin_sample | input | VW | Input-voltage converter sample |
| vin_valid | input | 1 | One-clock strobe marking a new input-voltage sample |
| vo_sample | input | VW | Output-voltage converter sample |
| vo_valid | input | 1 | One-clock strobe marking a new output-voltage sample |
| sw_on | input | 1 | Switch drive state produced by the controller |
| comp_trim | input | CW | Signed per-clock volt-second compensation |
| vin_extrap | output | VW | Extrapolated input voltage |
| vo_extrap | output | VW | Extrapolated output voltage |
| i_est | output | IW | Rebuilt inductor current |

## Verification
Some properties hold only when the inputs meet conditions. The checks on the direction of the estimate assume a non-negative trim when the switch is on, and a zero trim when the switch is off and the output voltage is above the input. Every property assumes the inputs are settled at the clock edge. The stimulus changes inputs only at falling edges, and it holds the trim at zero or positive in the phases where those direction checks would apply. Strobes come at the nominal period, at irregular intervals, and with jumps wide enough to drive each extrapolated channel into both of its limits.

// File: rtl/rebuild_pkg.sv
package rebuild_pkg;
  localparam int CH_VIN = 0;
  localparam int CH_VO  = 1;
  localparam int NUM_CH = 2;

  typedef enum logic {
    DRV_OFF = 1'b0,
    DRV_ON  = 1'b1
  } drive_e;
endpackage

// File: rtl/rb_extrapolator.sv
module rb_extrapolator #(
  parameter int VW        = 8,
  parameter int FRAC_BITS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [VW-1:0] sample,
  input  logic          valid,
  output logic [VW-1:0] vext
);
  localparam int EW      = VW + FRAC_BITS + 2;
  localparam int EST_MAX = (1 << (VW + FRAC_BITS)) - 1;
  localparam logic signed [EW:0] EST_MAX_W = $signed((EW+1)'(EST_MAX));

  logic signed [EW-1:0] est_q, slope_q;
  logic [VW-1:0]        prev_q;
  logic                 primed_q;

  // named events for the checks
  logic                 load_evt;
  logic                 first_evt;
  logic signed [VW:0]   diff_w;
  logic signed [EW-1:0] diff_ext;
  logic signed [EW-1:0] est_load;
  logic signed [EW-1:0] est_run;

  function automatic logic signed [EW-1:0] advance(
    input logic signed [EW-1:0] e,
    input logic signed [EW-1:0] s
  );
    logic signed [EW:0] t;
    t = {e[EW-1], e} + {s[EW-1], s};
    if (t < 0) return '0;
    if (t > EST_MAX_W) return EST_MAX_W[EW-1:0];
    return t[EW-1:0];
  endfunction

  assign load_evt  = valid;
  assign first_evt = valid && !primed_q;
  assign diff_w    = $signed({1'b0, sample}) - $signed({1'b0, prev_q});
  assign diff_ext  = {{(EW-VW-1){diff_w[VW]}}, diff_w};
  assign est_load  = {2'b00, sample, {FRAC_BITS{1'b0}}};
  assign est_run   = advance(est_q, slope_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      est_q    <= '0;
      slope_q  <= '0;
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else if (load_evt) begin
      est_q    <= est_load;
      slope_q  <= primed_q ? diff_ext : '0;
      prev_q   <= sample;
      primed_q <= 1'b1;
    end else begin
      est_q    <= est_run;
    end
  end

  assign vext = est_q[VW+FRAC_BITS-1:FRAC_BITS];

  AST_EXT_RESET: assert property (@(posedge clk)
    rst |=> (est_q == 0 && slope_q == 0 && !primed_q)); // R1
  AST_LOAD_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> vext == $past(sample)); // R2
  AST_FIRST_FLAT: assert property (@(posedge clk) disable iff (rst)
    first_evt |=> slope_q == 0); // R3
  AST_RUN_STEP: assert property (@(posedge clk) disable iff (rst)
    (!valid && slope_q == 0) |=> $stable(est_q)); // R4
  AST_EST_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (est_q >= 0) && (est_q <= $signed(EW'(EST_MAX)))); // R5
endmodule

// File: rtl/rb_vs_integrator.sv
module rb_vs_integrator
  import rebuild_pkg::*;
#(
  parameter int VW         = 8,
  parameter int CW         = 8,
  parameter int IW         = 12,
  parameter int GAIN_SHIFT = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [VW-1:0]        vin_x,
  input  logic [VW-1:0]        vo_x,
  input  logic                 sw_on,
  input  logic signed [CW-1:0] comp,
  output logic [IW-1:0]        i_est
);
  localparam int AW = IW + GAIN_SHIFT;
  localparam int SW = AW + 2;
  localparam int ACC_MAX = (1 << AW) - 1;
  localparam logic signed [SW-1:0] ACC_MAX_W = $signed(SW'(ACC_MAX));

  drive_e drv;
  logic [AW-1:0]        acc_q;
  logic signed [SW-1:0] base_w;
  logic signed [SW-1:0] sum_w;
  logic                 underflow_evt;
  logic                 overflow_evt;
  logic [AW-1:0]        acc_next;

  function automatic logic signed [SW-1:0] vs_step(
    input drive_e        d,
    input logic [VW-1:0] vi,
    input logic [VW-1:0] vo
  );
    logic signed [SW-1:0] a, b;
    a = $signed({{(SW-VW){1'b0}}, vi});
    b = $signed({{(SW-VW){1'b0}}, vo});
    return (d == DRV_ON) ? a : (a - b);
  endfunction

  function automatic logic [AW-1:0] clamp_acc(input logic signed [SW-1:0] s);
    if (s < 0) return '0;
    if (s > ACC_MAX_W) return ACC_MAX_W[AW-1:0];
    return s[AW-1:0];
  endfunction

  assign drv    = drive_e'(sw_on);
  assign base_w = vs_step(drv, vin_x, vo_x);
  assign sum_w  = $signed({2'b00, acc_q}) + base_w
                + $signed({{(SW-CW){comp[CW-1]}}, comp});
  assign underflow_evt = sum_w < 0;
  assign overflow_evt  = sum_w > ACC_MAX_W;
  assign acc_next      = clamp_acc(sum_w);

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_next;
  end

  assign i_est = acc_q[AW-1:GAIN_SHIFT];

  AST_ACC_RESET: assert property (@(posedge clk)
    rst |=> acc_q == 0); // R1
  AST_ON_NONDECREASING: assert property (@(posedge clk) disable iff (rst)
    (sw_on && !comp[CW-1]) |=> acc_q >= $past(acc_q)); // R6
  AST_OFF_FALLS: assert property (@(posedge clk) disable iff (rst)
    (!sw_on && vo_x > vin_x && comp == 0 && acc_q != 0) |=> acc_q < $past(acc_q)); // R7
  AST_FLOOR_ZERO: assert property (@(posedge clk) disable iff (rst)
    underflow_evt |=> acc_q == 0); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    overflow_evt |=> acc_q == ACC_MAX[AW-1:0]); // R9
endmodule

// File: rtl/boost_current_rebuilder.sv
module boost_current_rebuilder
  import rebuild_pkg::*;
#(
  parameter int VW         = 8,
  parameter int FRAC_BITS  = 3,
  parameter int CW         = 8,
  parameter int IW         = 12,
  parameter int GAIN_SHIFT = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [VW-1:0]        vin_sample,
  input  logic                 vin_valid,
  input  logic [VW-1:0]        vo_sample,
  input  logic                 vo_valid,
  input  logic                 sw_on,
  input  logic signed [CW-1:0] comp_trim,
  output logic [VW-1:0]        vin_extrap,
  output logic [VW-1:0]        vo_extrap,
  output logic [IW-1:0]        i_est
);
  logic [VW-1:0] smp   [NUM_CH];
  logic          vld   [NUM_CH];
  logic [VW-1:0] ext   [NUM_CH];

  assign smp[CH_VIN] = vin_sample;
  assign smp[CH_VO]  = vo_sample;
  assign vld[CH_VIN] = vin_valid;
  assign vld[CH_VO]  = vo_valid;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    rb_extrapolator #(
      .VW        (VW),
      .FRAC_BITS (FRAC_BITS)
    ) u_ext (
      .clk    (clk),
      .rst    (rst),
      .sample (smp[c]),
      .valid  (vld[c]),
      .vext   (ext[c])
    );
  end

  assign vin_extrap = ext[CH_VIN];
  assign vo_extrap  = ext[CH_VO];

  rb_vs_integrator #(
    .VW         (VW),
    .CW         (CW),
    .IW         (IW),
    .GAIN_SHIFT (GAIN_SHIFT)
  ) u_int (
    .clk   (clk),
    .rst   (rst),
    .vin_x (ext[CH_VIN]),
    .vo_x  (ext[CH_VO]),
    .sw_on (sw_on),
    .comp  (comp_trim),
    .i_est (i_est)
  );
endmodule

// File: tb/boost_current_rebuilder_tb.sv
module boost_current_rebuilder_tb;
  localparam int VW = 8, FB = 3, CW = 8, IW = 12, GS = 4;
  localparam int EST_MAX = (1 << (VW + FB)) - 1;
  localparam int ACC_MAX = (1 << (IW + GS)) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [VW-1:0] vin_sample = '0, vo_sample = '0;
  logic vin_valid = 1'b0, vo_valid = 1'b0, sw_on = 1'b0;
  logic signed [CW-1:0] comp_trim = '0;
  logic [VW-1:0] vin_extrap, vo_extrap;
  logic [IW-1:0] i_est;

  int checks = 0, fails = 0;
  bit done = 0;
  int m_est[2], m_slope[2], m_prev[2];
  bit m_primed[2];
  int m_acc;
  int unsigned seed = 32'h1234_5678;

  always #10 clk = ~clk;

  boost_current_rebuilder #(.VW(VW), .FRAC_BITS(FB), .CW(CW), .IW(IW), .GAIN_SHIFT(GS)) u_dut (
    .clk(clk), .rst(rst), .vin_sample(vin_sample), .vin_valid(vin_valid),
    .vo_sample(vo_sample), .vo_valid(vo_valid), .sw_on(sw_on), .comp_trim(comp_trim),
    .vin_extrap(vin_extrap), .vo_extrap(vo_extrap), .i_est(i_est));

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cmp_all(string tag);
    chk(tag, "vin_extrap", int'(vin_extrap), m_est[0] >> FB);
    chk(tag, "vo_extrap", int'(vo_extrap), m_est[1] >> FB);
    chk(tag, "i_est", int'(i_est), m_acc >> GS);
  endtask

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  // one clock: drive inputs, update the model, sample at the falling edge
  task automatic cyc(string tag, int vi, bit viv, int vo, bit vov, bit on, int comp);
    int vx, ox, s[2];
    bit v[2];
    vin_sample = VW'(vi); vin_valid = viv; vo_sample = VW'(vo); vo_valid = vov;
    sw_on = on; comp_trim = CW'(comp);
    vx = m_est[0] >> FB; ox = m_est[1] >> FB;
    m_acc = clampi(m_acc + (on ? vx : vx - ox) + comp, 0, ACC_MAX);
    s[0] = vi; s[1] = vo; v[0] = viv; v[1] = vov;
    for (int c = 0; c < 2; c++) begin
      if (v[c]) begin
        m_slope[c] = m_primed[c] ? s[c] - m_prev[c] : 0;
        m_est[c] = s[c] << FB;
        m_prev[c] = s[c];
        m_primed[c] = 1;
      end else begin
        m_est[c] = clampi(m_est[c] + m_slope[c], 0, EST_MAX);
      end
    end
    @(posedge clk); @(negedge clk);
    cmp_all(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; vin_valid = 0; vo_valid = 0; sw_on = 0; comp_trim = '0;
    @(posedge clk); @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      m_est[c] = 0; m_slope[c] = 0; m_prev[c] = 0; m_primed[c] = 0;
    end
    m_acc = 0;
    cmp_all("R1");
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R3: first sample flat, both channels
    cyc("R3", 100, 1, 40, 1, 0, 0);
    for (int k = 0; k < 20; k++) cyc("R3", 0, 0, 0, 0, 0, 0);

    // R2 and R4: near-exhaustive pairs, strobe every 2^FB clocks, switch held on
    do_reset();
    for (int a = 0; a < 256; a += 17) begin
      for (int b = 0; b < 256; b += 15) begin
        cyc("R2", a, 1, 255 - b, 1, 1, 0);
        for (int k = 1; k < 8; k++) cyc("R4", 0, 0, 0, 0, 1, 0);
        cyc("R2", b, 1, a, 1, 1, 0);
        for (int k = 1; k < 8; k++) cyc("R4", 0, 0, 0, 0, 1, 0);
      end
      do_reset();
    end

    // R5: steep slopes with no further strobes saturate at both ends
    cyc("R5", 0, 1, 255, 1, 1, 0);
    cyc("R5", 255, 1, 0, 1, 1, 0);
    for (int k = 0; k < 40; k++) cyc("R5", 0, 0, 0, 0, 1, 0);
    cyc("R5", 0, 1, 255, 1, 1, 0);
    for (int k = 0; k < 40; k++) cyc("R5", 0, 0, 0, 0, 1, 0);

    // R6 and R10: PWM with positive trim and a rising ramp
    do_reset();
    cyc("R6", 60, 1, 200, 1, 1, 3);
    for (int p = 0; p < 40; p++)
      for (int k = 0; k < 16; k++)
        cyc("R6/R10", 60 + p, k == 0, 200, k == 0, k < 11, 3);

    // R7: off phases with vo above vin pull the estimate down; R8 floor
    for (int k = 0; k < 200; k++) cyc("R7", 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 50; k++) cyc("R8", 0, 0, 0, 0, 0, -5);

    // R9: saturation at the accumulator maximum
    do_reset();
    cyc("R9", 255, 1, 0, 1, 1, 127);
    for (int k = 0; k < 260; k++) cyc("R9", 0, 0, 0, 0, 1, 127);
    cyc("R9", 0, 0, 0, 0, 0, 0);

    // R2/R4/R10: irregular strobe timing and duty with signed trim
    do_reset();
    for (int k = 0; k < 3000; k++) begin
      seed = seed * 1103515245 + 12345;
      cyc("R4/R10", int'(seed[23:16]), seed[3:0] == 0, int'(seed[31:24]), seed[7:4] == 1,
          seed[9], $signed(seed[14:11]) - 2);
    end

    // R1: reset mid-run clears everything
    do_reset();
    cyc("R1", 0, 0, 0, 0, 1, 0);
    finish_run();
  end
endmodule